// File: doc/BRIEF.md
# USB Endpoint Handshake Response Controller

This block is the control logic for one endpoint of a USB device controller. It holds the endpoint's configuration word and decides how the endpoint answers each transaction the serial interface engine reports. The settings are the largest packet payload, a two-bit reply mode, a buffer flush bit, an OUT auto-discard bit, an append-empty-packet bit and a narrow (8-bit) data-port bit. Each reply is one of NAK, ACK, STALL, DATA0 or DATA1. For a data reply the block also gives the byte length of the packet to send.

A small queue tracks the endpoint's one or two packet buffers. For an IN endpoint the CPU commits filled buffers, and a host ACK retires them. For an OUT endpoint, accepted packets are queued and shown to the CPU until it releases them. The block switches itself to STALL when an OUT packet is larger than the configured limit. After a full-size final IN packet in a continuous transfer, it also sends an empty packet.

Top module: `usb_ep_resp_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x1000, with a limit of 64 and all other fields 0. There is no reply, the toggle is 0, the buffers are empty and both data-port byte lanes are enabled. The word layout is: bits [1:0] reply mode, [2] flush, [3] OUT auto-discard, [4] append empty packet, [5] narrow port, [15:6] packet limit.
- R2: With reply mode 00, every IN token or OUT packet is answered NAK (code 0), whatever the buffers hold.
- R3: With reply mode 10 or 11, every IN token or OUT packet is answered STALL (code 2).
- R4: In mode 01, an IN token on an empty endpoint gets NAK. Otherwise the reply is DATA0 (code 3) or DATA1 (code 4), chosen by the toggle, with tx_len equal to the oldest committed length. A token with no host ACK in between resends the same packet. A host ACK retires that packet and flips the toggle.
- R5: In mode 01, an OUT packet no larger than the limit is answered ACK (code 1) while a buffer is free. It is then readable with its byte count, and the toggle flips. When all buffers are full the answer is NAK.
- R6: In mode 01, an OUT packet whose count exceeds the limit gets STALL, the reply mode becomes 10 with no write, and the toggle returns to 0.
- R7: If append-empty-packet is on and the continuous-transfer input is high, a host ACK of a packet exactly as long as the limit that empties the queue makes the next IN token answer with a data packet of length 0. With continuous transfer low, no empty packet follows.
- R8: While the reply mode is not 00, a configuration write changes only the reply mode bits.
- R9: While the flush bit is set, all buffers are emptied, a pending empty packet is dropped, the toggle returns to 0 and CPU commits are ignored.
- R10: With OUT auto-discard on, OUT packets are answered ACK but never become readable.
- R11: lane_en is 2'b01 when the narrow-port bit is set and 2'b11 otherwise.
- R12: Entering STALL by a configuration write returns the toggle to 0.
- R13: With two buffers, packets are handled oldest first, buf_full is raised when both are occupied, and a commit to a full endpoint is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | MPS_W+6 | Configuration write data |
| cfg_q | output | MPS_W+6 | Current configuration word |
| dir_in | input | 1 | Endpoint direction, 1 = IN |
| cont_tx | input | 1 | Continuous transfer in progress |
| tok_in | input | 1 | IN token received |
| out_done | input | 1 | OUT packet received completely |
| out_cnt | input | MPS_W+1 | Byte count of that OUT packet |
| host_ack | input | 1 | Host acknowledged the last IN data packet |
| cpu_commit | input | 1 | CPU filled an IN buffer |
| cpu_len | input | MPS_W | Byte length of the committed buffer |
| cpu_release | input | 1 | CPU finished reading the oldest OUT buffer |
| hs_valid | output | 1 | Reply valid for one cycle |
| hs_code | output | 3 | Reply: 0 NAK, 1 ACK, 2 STALL, 3 DATA0, 4 DATA1 |
| tx_len | output | MPS_W | Length of the data packet to send |
| rd_valid | output | 1 | OUT buffer readable by the CPU |
| rd_len | output | MPS_W | Byte count of the readable buffer |
| buf_full | output | 1 | All buffers occupied |
| toggle | output | 1 | Current data toggle |
| lane_en | output | 2 | Data-port byte lane enables |

## Verification
The bench builds the block with two buffers and a 10-bit limit field. At run time it programs the limit to 8 bytes, so packet counts of 9 and exactly 8 reach the oversize STALL and the empty-packet append with short stimulus. Two buffers let one sequence show ordering, the full state, a refused commit and NAK on a full OUT endpoint.

// File: rtl/usb_ep_resp_ctrl.sv
module usb_ep_resp_ctrl #(
  parameter int MPS_W   = 10,
  parameter int NBUF    = 2,
  parameter int MPS_RST = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [MPS_W+5:0] cfg_wdata,
  output logic [MPS_W+5:0] cfg_q,
  input  logic             dir_in,
  input  logic             cont_tx,
  input  logic             tok_in,
  input  logic             out_done,
  input  logic [MPS_W:0]   out_cnt,
  input  logic             host_ack,
  input  logic             cpu_commit,
  input  logic [MPS_W-1:0] cpu_len,
  input  logic             cpu_release,
  output logic             hs_valid,
  output logic [2:0]       hs_code,
  output logic [MPS_W-1:0] tx_len,
  output logic             rd_valid,
  output logic [MPS_W-1:0] rd_len,
  output logic             buf_full,
  output logic             toggle,
  output logic [1:0]       lane_en
);
  localparam int PW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int CW = $clog2(NBUF + 1);
  localparam logic [CW-1:0] NB = CW'(NBUF);
  localparam logic [2:0] HS_NAK = 3'd0, HS_ACK = 3'd1, HS_STALL = 3'd2,
                         HS_D0  = 3'd3, HS_D1  = 3'd4;

  logic [1:0]       resp_q, resp_nx;
  logic             clr_q, aclr_q, zlp_q, byte_q;
  logic [MPS_W-1:0] mps_q;
  logic [MPS_W-1:0] len_q [NBUF];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q;
  logic             tog_q, zpend_q, await_q, sentz_q;
  logic [2:0]       code_d;
  logic [MPS_W-1:0] len_d;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NBUF - 1)) ? '0 : p + 1'b1;
  endfunction

  wire buf_m   = (resp_q == 2'b01);
  wire flush   = clr_q | (aclr_q & ~dir_in);
  wire empty   = (cnt_q == '0);
  wire full    = (cnt_q == NB);
  wire [MPS_W-1:0] head = len_q[rd_ptr];
  wire in_ev   = tok_in & dir_in;
  wire out_ev  = out_done & ~dir_in;
  wire over    = out_cnt > {1'b0, mps_q};
  wire in_send = in_ev & buf_m & (zpend_q | ~empty);
  wire out_ack = out_ev & buf_m & ~over & ~(full & ~aclr_q);
  wire auto_st = out_ev & buf_m & over;
  wire ack_ok  = host_ack & await_q;
  wire pop_in  = ack_ok & ~sentz_q;
  wire pop_out = cpu_release & ~dir_in & ~empty;
  wire push_in = cpu_commit & dir_in & ~full & ~flush;
  wire push_out = out_ack & ~flush;
  wire do_push = push_in | push_out;
  wire do_pop  = pop_in | pop_out;
  wire [MPS_W-1:0] push_len = push_in ? cpu_len : out_cnt[MPS_W-1:0];
  wire set_zp  = pop_in & zlp_q & cont_tx & (head == mps_q) & (cnt_q == CW'(1));
  wire stall_in = resp_nx[1] & ~resp_q[1];

  always_comb begin
    resp_nx = resp_q;
    if (cfg_we) resp_nx = cfg_wdata[1:0];
    if (auto_st) resp_nx = 2'b10;
  end

  always_comb begin
    code_d = HS_NAK;
    len_d  = '0;
    if (resp_q[1]) code_d = HS_STALL;
    else if (buf_m) begin
      if (in_send) begin
        code_d = tog_q ? HS_D1 : HS_D0;
        len_d  = zpend_q ? '0 : head;
      end else if (auto_st) code_d = HS_STALL;
      else if (out_ack)     code_d = HS_ACK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= 2'b00; clr_q <= 1'b0; aclr_q <= 1'b0; zlp_q <= 1'b0;
      byte_q <= 1'b0;  mps_q <= MPS_W'(MPS_RST);
    end else begin
      resp_q <= resp_nx;
      if (cfg_we && resp_q == 2'b00) begin
        clr_q  <= cfg_wdata[2];
        aclr_q <= cfg_wdata[3];
        zlp_q  <= cfg_wdata[4];
        byte_q <= cfg_wdata[5];
        mps_q  <= cfg_wdata[MPS_W+5:6];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) len_q[wr_ptr] <= push_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt_q <= '0;
    end else if (flush) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0; zpend_q <= 1'b0; await_q <= 1'b0; sentz_q <= 1'b0;
    end else begin
      if (in_send) sentz_q <= zpend_q;
      if (flush || stall_in) begin
        tog_q <= 1'b0; zpend_q <= 1'b0; await_q <= 1'b0;
      end else begin
        if (ack_ok || out_ack) tog_q <= ~tog_q;
        if (set_zp) zpend_q <= 1'b1;
        else if (ack_ok && sentz_q) zpend_q <= 1'b0;
        if (in_send) await_q <= 1'b1;
        else if (ack_ok) await_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid <= 1'b0; hs_code <= HS_NAK; tx_len <= '0;
    end else begin
      hs_valid <= in_ev | out_ev;
      hs_code  <= code_d;
      tx_len   <= len_d;
    end
  end

  assign cfg_q    = {mps_q, byte_q, zlp_q, aclr_q, clr_q, resp_q};
  assign rd_valid = ~dir_in & ~empty;
  assign rd_len   = head;
  assign buf_full = full;
  assign toggle   = tog_q;
  assign lane_en  = byte_q ? 2'b01 : 2'b11;
endmodule

module usb_ep_resp_ctrl_chk #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_q,
  input logic             hs_valid,
  input logic [2:0]       hs_code,
  input logic             toggle,
  input logic             buf_full,
  input logic             rd_valid
);
  AST_NAK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid && $past(cfg_q[1:0]) == 2'b00 |-> hs_code == 3'd0); // R2
  AST_STALL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid && $past(cfg_q[1]) |-> hs_code == 3'd2); // R3
  AST_AUTO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q[1]) && !$past(cfg_we) |-> hs_valid && hs_code == 3'd2); // R6
  AST_STALL_TOG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q[1]) |-> !toggle); // R12
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_q[1:0]) != 2'b00 |-> cfg_q[CFG_W-1:2] == $past(cfg_q[CFG_W-1:2])); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[2] |=> !buf_full && !rd_valid && !toggle); // R9
endmodule

bind usb_ep_resp_ctrl usb_ep_resp_ctrl_chk #(.CFG_W(MPS_W + 6)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_q(cfg_q),
  .hs_valid(hs_valid), .hs_code(hs_code), .toggle(toggle),
  .buf_full(buf_full), .rd_valid(rd_valid)
);

// File: tb/usb_ep_resp_ctrl_tb.sv
`timescale 1ns/1ps
module usb_ep_resp_ctrl_tb;
  localparam int MPS_W = 10;
  localparam int NBUF  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, dir_in = 1, cont_tx = 0, tok_in = 0, out_done = 0;
  logic host_ack = 0, cpu_commit = 0, cpu_release = 0;
  logic [MPS_W+5:0] cfg_wdata = '0, cfg_q;
  logic [MPS_W:0] out_cnt = '0;
  logic [MPS_W-1:0] cpu_len = '0, tx_len, rd_len;
  logic hs_valid, rd_valid, buf_full, toggle;
  logic [2:0] hs_code;
  logic [1:0] lane_en;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  usb_ep_resp_ctrl #(.MPS_W(MPS_W), .NBUF(NBUF), .MPS_RST(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .dir_in(dir_in), .cont_tx(cont_tx), .tok_in(tok_in), .out_done(out_done),
    .out_cnt(out_cnt), .host_ack(host_ack), .cpu_commit(cpu_commit), .cpu_len(cpu_len),
    .cpu_release(cpu_release), .hs_valid(hs_valid), .hs_code(hs_code), .tx_len(tx_len),
    .rd_valid(rd_valid), .rd_len(rd_len), .buf_full(buf_full), .toggle(toggle),
    .lane_en(lane_en));

  // behavioural reference
  int m_resp, m_clr, m_aclr, m_zlp, m_byte, m_mps, m_tog, m_zp, m_aw, m_sz;
  int m_hv, m_hc, m_tl;
  int q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_resp = 0; m_clr = 0; m_aclr = 0; m_zlp = 0; m_byte = 0; m_mps = 64;
      m_tog = 0; m_zp = 0; m_aw = 0; m_sz = 0; m_hv = 0; m_hc = 0; m_tl = 0;
      q.delete();
    end else begin
      int old_resp, nresp, hc, tl, hv, send, sendz, oack, auto_s, ackok, fl, h;
      old_resp = m_resp; nresp = m_resp;
      fl = (m_clr != 0) || (m_aclr != 0 && !dir_in);
      hv = 0; hc = 0; tl = 0; send = 0; sendz = 0; oack = 0; auto_s = 0;
      if (tok_in && dir_in) begin
        hv = 1;
        if (m_resp >= 2) hc = 2;
        else if (m_resp == 1) begin
          if (m_zp != 0) begin send = 1; sendz = 1; hc = m_tog ? 4 : 3; tl = 0; end
          else if (q.size() > 0) begin send = 1; hc = m_tog ? 4 : 3; tl = q[0]; end
        end
      end
      if (out_done && !dir_in) begin
        hv = 1;
        if (m_resp >= 2) hc = 2;
        else if (m_resp == 1) begin
          if (int'(out_cnt) > m_mps) begin hc = 2; auto_s = 1; end
          else if (m_aclr == 0 && q.size() == NBUF) hc = 0;
          else begin hc = 1; oack = 1; end
        end
      end
      ackok = host_ack && m_aw != 0;
      if (ackok) begin
        if (m_sz != 0) m_zp = 0;
        else begin
          h = q.pop_front();
          if (h == m_mps && m_zlp != 0 && cont_tx && q.size() == 0) m_zp = 1;
        end
      end
      if (cpu_release && !dir_in && q.size() > 0) void'(q.pop_front());
      if (cpu_commit && dir_in && q.size() < NBUF && !fl) q.push_back(int'(cpu_len));
      if (oack && !fl) q.push_back(int'(out_cnt));
      if (send) begin m_sz = sendz; m_aw = 1; end
      else if (ackok) m_aw = 0;
      if (ackok || oack) m_tog = 1 - m_tog;
      if (cfg_we) begin
        if (old_resp == 0) begin
          m_clr = cfg_wdata[2]; m_aclr = cfg_wdata[3]; m_zlp = cfg_wdata[4];
          m_byte = cfg_wdata[5]; m_mps = int'(cfg_wdata[MPS_W+5:6]);
        end
        nresp = int'(cfg_wdata[1:0]);
      end
      if (auto_s) nresp = 2;
      m_resp = nresp;
      if (fl || (nresp >= 2 && old_resp < 2)) begin
        m_tog = 0; m_zp = 0; m_aw = 0;
        if (fl) q.delete();
      end
      m_hv = hv; m_hc = hc; m_tl = tl;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int ecfg;
      ecfg = (m_mps << 6) | (m_byte << 5) | (m_zlp << 4) | (m_aclr << 3) | (m_clr << 2) | m_resp;
      chk(int'(cfg_q) == ecfg, "R8 cfg_q", int'(cfg_q), ecfg);
      chk(int'(hs_valid) == m_hv, "R4 hs_valid", int'(hs_valid), m_hv);
      if (m_hv != 0) begin
        chk(int'(hs_code) == m_hc, "R4 hs_code", int'(hs_code), m_hc);
        chk(int'(tx_len) == m_tl, "R7 tx_len", int'(tx_len), m_tl);
      end
      chk(int'(toggle) == m_tog, "R12 toggle", int'(toggle), m_tog);
      chk(int'(buf_full) == (q.size() == NBUF), "R13 buf_full", int'(buf_full), int'(q.size() == NBUF));
      chk(int'(rd_valid) == (!dir_in && q.size() > 0), "R5 rd_valid", int'(rd_valid), int'(!dir_in && q.size() > 0));
      if (rd_valid && q.size() > 0) chk(int'(rd_len) == q[0], "R5 rd_len", int'(rd_len), q[0]);
      chk(int'(lane_en) == (m_byte ? 1 : 3), "R11 lane_en", int'(lane_en), m_byte ? 1 : 3);
    end
  end

  task automatic step(); @(posedge clk); #2; endtask
  task automatic wcfg(input int d); cfg_we = 1; cfg_wdata = d[15:0]; step(); cfg_we = 0; endtask
  task automatic commit(input int n); cpu_commit = 1; cpu_len = n[9:0]; step(); cpu_commit = 0; endtask
  task automatic ack(); host_ack = 1; step(); host_ack = 0; endtask
  task automatic release_buf(); cpu_release = 1; step(); cpu_release = 0; endtask
  task automatic in_tok(input int code, input int len, input string tag);
    tok_in = 1; step(); tok_in = 0;
    chk(hs_valid && int'(hs_code) == code, tag, int'(hs_code), code);
    if (code >= 3) chk(int'(tx_len) == len, tag, int'(tx_len), len);
  endtask
  task automatic out_pkt(input int n, input int code, input string tag);
    out_done = 1; out_cnt = n[10:0]; step(); out_done = 0;
    chk(hs_valid && int'(hs_code) == code, tag, int'(hs_code), code);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk(cfg_q == 16'h1000, "R1 cfg reset", int'(cfg_q), 'h1000);
    chk(!hs_valid && !toggle && !buf_full, "R1 idle", int'({hs_valid, toggle, buf_full}), 0);
    chk(lane_en == 2'b11, "R1 lanes", int'(lane_en), 3);
    dir_in = 1;
    wcfg('h200);
    in_tok(0, 0, "R2 nak empty");
    commit(5);
    in_tok(0, 0, "R2 nak with data");
    wcfg('h201);
    in_tok(3, 5, "R4 data0");
    in_tok(3, 5, "R4 retry");
    ack();
    chk(toggle == 1'b1, "R4 toggle flip", int'(toggle), 1);
    in_tok(0, 0, "R4 nak empty");
    commit(3); commit(4);
    chk(buf_full == 1'b1, "R13 full", int'(buf_full), 1);
    commit(6);
    in_tok(4, 3, "R13 oldest first");
    ack();
    in_tok(3, 4, "R13 second");
    ack();
    in_tok(0, 0, "R13 extra commit ignored");
    wcfg('h200); wcfg('h210); wcfg('h211);
    cont_tx = 1;
    commit(8);
    in_tok(4, 8, "R7 full packet");
    ack();
    in_tok(3, 0, "R7 empty packet");
    ack();
    in_tok(0, 0, "R7 done");
    cont_tx = 0;
    commit(8);
    in_tok(4, 8, "R7 no cont");
    ack();
    in_tok(0, 0, "R7 no append");
    commit(2);
    in_tok(3, 2, "R12 data");
    ack();
    wcfg('h7FC2);
    chk(cfg_q == 16'h0212, "R8 locked", int'(cfg_q), 'h212);
    chk(toggle == 1'b0, "R12 stall toggle", int'(toggle), 0);
    in_tok(2, 0, "R3 stall 10");
    wcfg('h7FC3);
    in_tok(2, 0, "R3 stall 11");
    wcfg('h0000);
    chk(cfg_q == 16'h0210, "R8 resp only", int'(cfg_q), 'h210);
    commit(5); commit(6);
    wcfg('h214);
    step();
    chk(buf_full == 1'b0, "R9 flushed", int'(buf_full), 0);
    commit(3);
    wcfg('h210); wcfg('h211);
    in_tok(0, 0, "R9 commit ignored");
    dir_in = 0;
    wcfg('h210); wcfg('h201);
    out_pkt(5, 1, "R5 ack");
    chk(rd_valid && rd_len == 10'd5, "R5 readable", int'(rd_len), 5);
    out_pkt(7, 1, "R5 ack2");
    out_pkt(3, 0, "R5 nak full");
    release_buf();
    chk(rd_len == 10'd7, "R13 out order", int'(rd_len), 7);
    release_buf();
    out_pkt(2, 1, "R5 ack3");
    release_buf();
    out_pkt(9, 2, "R6 oversize");
    chk(cfg_q == 16'h0202 && !toggle, "R6 auto stall", int'(cfg_q), 'h202);
    wcfg('h200); wcfg('h208); wcfg('h209);
    out_pkt(4, 1, "R10 ack");
    chk(rd_valid == 1'b0, "R10 hidden", int'(rd_valid), 0);
    wcfg('h200); wcfg('h220);
    chk(lane_en == 2'b01, "R11 narrow", int'(lane_en), 1);
    step(); step();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule